// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block sits beside a processor and turns its status lines into the timing and strobes of each bus cycle. The active-low status pair marks a pending cycle and says whether it reads or writes. A memory/I/O select picks which command family is used. The controller steps every cycle through a status state, in which it pulses the address latch enable, and then one or more command states. In the command states it drives one of four active-low command strobes: memory read, memory write, I/O read or I/O write. It also drives a data-enable and a data-direction signal for the data transceivers.

A ready input stretches the command state with wait states. When the status lines already show a new request at the edge that ends a cycle, the next cycle starts at once with no idle state between. A static strap selects one of two timings. Fast local timing enables write data from the status state onward, so back-to-back writes keep the transceivers on across the cycle boundary. System-bus timing confines write data enable to the command state and lets two extra inputs hold commands off: a command-delay input and an address-enable input.

Top module: `busCycleCtl`

## Requirements
- R1: While rstN is low the controller is idle, all four command strobes are high, and ale, den and dtR are low.
- R2: In the idle state, statusN = 2'b10 (read) or 2'b01 (write) starts a cycle, and ale is high in the following clock. The codes 2'b11 and 2'b00 leave the controller idle with ale low.
- R3: memIoSel, sampled with the starting status code, picks the family of the cycle: 1 selects the memory strobes and 0 selects the I/O strobes. At most one command strobe is low at any time.
- R4: ale is high for exactly one clock per cycle (the status state) and low in every other state.
- R5: The command state follows the status state. Its strobe stays low through every clock in which readyN is sampled high (wait states). It goes high on the edge where readyN is sampled low, and that edge ends the cycle.
- R6: If statusN shows a read or write code at the edge that ends a cycle, the next cycle's status state follows immediately with no idle state. Its outputs are timed exactly as those of an isolated cycle.
- R7: During a read, dtR stays low, and den is high in the command state only.
- R8: With sysMode = 0, a write holds dtR and den high from its status state through its last command clock. Consecutive writes therefore keep both high across the boundary.
- R9: With sysMode = 1, a write drives dtR and den high in its command state only, so both drop during the status state of a following write.
- R10: With sysMode = 1, the command strobe is withheld until the first edge in the command phase at which cmdDelay is sampled low. The edge entering the command state counts. With sysMode = 0, cmdDelay has no effect.
- R11: With sysMode = 1, addrEnN high forces all command strobes high in the same clock. With sysMode = 0, addrEnN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| statusN | input | 2 | Processor status, active low: 11 idle, 10 read, 01 write |
| memIoSel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| readyN | input | 1 | Ready, active low; high adds a wait state |
| sysMode | input | 1 | Strap: 1 = system-bus timing, 0 = fast local timing |
| cmdDelay | input | 1 | Command delay request (system-bus timing only) |
| addrEnN | input | 1 | Address/command enable, active low (system-bus timing only) |
| ale | output | 1 | Address latch enable |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| den | output | 1 | Data transceiver enable |
| dtR | output | 1 | Data direction: 1 transmit (write), 0 receive |

## Verification
The situation hardest to bring about from the ports is a cycle boundary with no idle state between. Ready must be seen low at the same edge where a fresh read or write code is already on the status lines. Only then do the direction and enable hand over correctly, and they differ between the two straps. Directed sequences in both modes place the next code on statusN during the final wait clock. A long random run then mixes ready, command delay, address enable and the unused 00 code so these boundaries recur under many combinations. Every output is compared each clock against a bench model built from the requirements.

// File: rtl/busCtlPkg.sv
package busCtlPkg;
  localparam int STATUS_W = 2;
  localparam logic [STATUS_W-1:0] CODE_IDLE  = 2'b11;
  localparam logic [STATUS_W-1:0] CODE_READ  = 2'b10;
  localparam logic [STATUS_W-1:0] CODE_WRITE = 2'b01;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STATUS = 2'd1,
    PH_CMD    = 2'd2
  } phaseT;

  // strobes from the sequencer to the output decode
  typedef struct packed {
    logic inStatus;
    logic inCmd;
    logic cmdLive;
    logic isWrite;
    logic isMem;
  } ctlStrobesT;
endpackage

// File: rtl/busCtlSeq.sv
module busCtlSeq
  import busCtlPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] statusN,
  input  logic                memIoSel,
  input  logic                readyN,
  input  logic                sysMode,
  input  logic                cmdDelay,
  output ctlStrobesT          strobes
);
  phaseT phase, phaseNxt;
  logic  isWrite, isMem, cmdLive;
  logic  isWriteNxt, isMemNxt, cmdLiveNxt;
  logic  reqValid, holdOff, cycleEnd;

  assign reqValid = (statusN == CODE_READ) || (statusN == CODE_WRITE);
  assign holdOff  = sysMode && cmdDelay;
  assign cycleEnd = (phase == PH_CMD) && !readyN;

  always_comb begin
    phaseNxt   = phase;
    isWriteNxt = isWrite;
    isMemNxt   = isMem;
    cmdLiveNxt = cmdLive;
    unique case (phase)
      PH_IDLE: begin
        cmdLiveNxt = 1'b0;
        if (reqValid) begin
          phaseNxt   = PH_STATUS;
          isWriteNxt = (statusN == CODE_WRITE);
          isMemNxt   = memIoSel;
        end
      end
      PH_STATUS: begin
        phaseNxt   = PH_CMD;
        cmdLiveNxt = !holdOff;
      end
      PH_CMD: begin
        if (cycleEnd) begin
          cmdLiveNxt = 1'b0;
          if (reqValid) begin
            phaseNxt   = PH_STATUS;
            isWriteNxt = (statusN == CODE_WRITE);
            isMemNxt   = memIoSel;
          end else begin
            phaseNxt = PH_IDLE;
          end
        end else if (!cmdLive && !holdOff) begin
          cmdLiveNxt = 1'b1;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      isWrite <= 1'b0;
      isMem   <= 1'b0;
      cmdLive <= 1'b0;
    end else begin
      phase   <= phaseNxt;
      isWrite <= isWriteNxt;
      isMem   <= isMemNxt;
      cmdLive <= cmdLiveNxt;
    end
  end

  assign strobes.inStatus = (phase == PH_STATUS);
  assign strobes.inCmd    = (phase == PH_CMD);
  assign strobes.cmdLive  = cmdLive;
  assign strobes.isWrite  = isWrite;
  assign strobes.isMem    = isMem;
endmodule

// File: rtl/busCtlOut.sv
module busCtlOut
  import busCtlPkg::*;
#(
  parameter int N_CMD = 4
)(
  input  ctlStrobesT       strobes,
  input  logic             sysMode,
  input  logic             addrEnN,
  output logic             ale,
  output logic [N_CMD-1:0] cmdN,
  output logic             den,
  output logic             dtR
);
  localparam int IDX_MEM_RD = 0;
  localparam int IDX_MEM_WR = 1;
  localparam int IDX_IO_RD  = 2;
  localparam int IDX_IO_WR  = 3;

  logic cmdOn;
  logic [N_CMD-1:0] sel;
  logic earlyWrite;

  assign cmdOn = strobes.inCmd && strobes.cmdLive && (!sysMode || !addrEnN);

  always_comb begin
    sel = '0;
    sel[IDX_MEM_RD] =  strobes.isMem && !strobes.isWrite;
    sel[IDX_MEM_WR] =  strobes.isMem &&  strobes.isWrite;
    sel[IDX_IO_RD]  = !strobes.isMem && !strobes.isWrite;
    sel[IDX_IO_WR]  = !strobes.isMem &&  strobes.isWrite;
  end

  for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
    assign cmdN[i] = !(cmdOn && sel[i]);
  end

  // fast timing turns write data on already in the status state
  assign earlyWrite = strobes.isWrite && strobes.inStatus && !sysMode;

  assign ale = strobes.inStatus;
  assign den = strobes.inCmd || earlyWrite;
  assign dtR = (strobes.isWrite && strobes.inCmd) || earlyWrite;
endmodule

// File: rtl/busCycleCtl.sv
module busCycleCtl
  import busCtlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] statusN,
  input  logic       memIoSel,
  input  logic       readyN,
  input  logic       sysMode,
  input  logic       cmdDelay,
  input  logic       addrEnN,
  output logic       ale,
  output logic       memRdN,
  output logic       memWrN,
  output logic       ioRdN,
  output logic       ioWrN,
  output logic       den,
  output logic       dtR
);
  localparam int N_CMD = 4;
  ctlStrobesT       strobes;
  logic [N_CMD-1:0] cmdN;

  busCtlSeq u_seq (
    .clk(clk), .rstN(rstN), .statusN(statusN), .memIoSel(memIoSel),
    .readyN(readyN), .sysMode(sysMode), .cmdDelay(cmdDelay),
    .strobes(strobes)
  );

  busCtlOut #(.N_CMD(N_CMD)) u_out (
    .strobes(strobes), .sysMode(sysMode), .addrEnN(addrEnN),
    .ale(ale), .cmdN(cmdN), .den(den), .dtR(dtR)
  );

  assign memRdN = cmdN[0];
  assign memWrN = cmdN[1];
  assign ioRdN  = cmdN[2];
  assign ioWrN  = cmdN[3];
endmodule

// File: rtl/busCycleCtlChk.sv
module busCycleCtlChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] statusN,
  input logic       readyN,
  input logic       ale,
  input logic       memRdN,
  input logic       memWrN,
  input logic       ioRdN,
  input logic       ioWrN,
  input logic       den,
  input logic       dtR
);
  logic anyCmd;
  assign anyCmd = !(memRdN && memWrN && ioRdN && ioWrN);

  a_r3_one_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!memRdN, !memWrN, !ioRdN, !ioWrN}) <= 1);

  a_r4_ale_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  a_r2_ale_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |-> $past(statusN != 2'b11));

  a_r5_ready_ends_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (anyCmd && !readyN) |=> !anyCmd);

  a_r7_read_receives: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdN || !ioRdN) |-> (den && !dtR));

  a_r4_no_cmd_with_ale: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> !anyCmd);
endmodule

bind busCycleCtl busCycleCtlChk u_chk (
  .clk(clk), .rstN(rstN), .statusN(statusN), .readyN(readyN), .ale(ale),
  .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
  .den(den), .dtR(dtR)
);

// File: tb/sim_busCycleCtl.sv
`timescale 1ns/1ps
module sim_busCycleCtl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] statusN = 2'b11;
  logic memIoSel = 1'b0, readyN = 1'b1, sysMode = 1'b0;
  logic cmdDelay = 1'b0, addrEnN = 1'b0;
  logic ale, memRdN, memWrN, ioRdN, ioWrN, den, dtR;

  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busCycleCtl u0 (.*);

  // reference model from the requirements
  typedef enum int {M_IDLE, M_STATUS, M_CMD} mPhaseT;
  mPhaseT mPh = M_IDLE;
  bit mWr = 0, mMem = 0, mLive = 0;

  function automatic bit isReq(logic [1:0] c);
    return (c == 2'b10) || (c == 2'b01);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = M_IDLE; mWr = 0; mMem = 0; mLive = 0;
    end else begin
      case (mPh)
        M_IDLE: if (isReq(statusN)) begin
          mPh = M_STATUS; mWr = (statusN == 2'b01); mMem = memIoSel;
        end
        M_STATUS: begin
          mPh = M_CMD; mLive = !(sysMode && cmdDelay);
        end
        M_CMD: begin
          if (!readyN) begin
            mLive = 0;
            if (isReq(statusN)) begin
              mPh = M_STATUS; mWr = (statusN == 2'b01); mMem = memIoSel;
            end else mPh = M_IDLE;
          end else if (!mLive && !(sysMode && cmdDelay)) mLive = 1;
        end
      endcase
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit on;
      bit [3:0] expCmd;
      bit expDen, expDir, expAle;
      on = (mPh == M_CMD) && mLive && (!sysMode || !addrEnN);
      expCmd = 4'b1111;
      if (on) expCmd[{!mMem, mWr}] = 1'b0;
      expAle = (mPh == M_STATUS);
      expDen = (mPh == M_CMD) || (mWr && !sysMode && mPh == M_STATUS);
      expDir = (mWr && mPh == M_CMD) || (mWr && !sysMode && mPh == M_STATUS);
      check(ale == expAle, "R4 R2 R6 ale", ale, expAle);
      check({ioWrN, ioRdN, memWrN, memRdN} == expCmd,
            sysMode ? "R3 R5 R10 R11 cmd" : "R3 R5 R6 cmd",
            {ioWrN, ioRdN, memWrN, memRdN}, expCmd);
      check(den == expDen && dtR == expDir,
            !mWr ? "R7 den/dtR" : (sysMode ? "R9 den/dtR" : "R8 den/dtR"),
            {den, dtR}, {expDen, expDir});
    end
  end

  task automatic step(logic [1:0] st, logic mio, logic rdy, logic cd, logic ae);
    @(negedge clk); #1;
    statusN = st; memIoSel = mio; readyN = rdy; cmdDelay = cd; addrEnN = ae;
  endtask

  task automatic doReset(logic mode);
    @(negedge clk); #1;
    rstN = 0; sysMode = mode; statusN = 2'b11; readyN = 1; cmdDelay = 0; addrEnN = 0;
    @(negedge clk); #1;
    check({ioWrN, ioRdN, memWrN, memRdN, ale, den, dtR} == 7'b1111000, "R1 reset",
          {ioWrN, ioRdN, memWrN, memRdN, ale, den, dtR}, 7'b1111000);
    rstN = 1;
  endtask

  initial begin
    doReset(1'b0);
    // idle-read-idle, fast mode
    step(2'b10, 1, 1, 0, 0);
    step(2'b11, 1, 1, 0, 0);
    #2 check(ale == 1, "R2 ale after read code", ale, 1);
    step(2'b11, 1, 0, 0, 0);
    #2 check(memRdN == 0 && den == 1 && dtR == 0, "R7 read command", {memRdN, den, dtR}, 3'b010);
    step(2'b11, 1, 1, 0, 0);
    // code 00 ignored
    step(2'b00, 0, 1, 0, 0);
    step(2'b11, 0, 1, 0, 0);
    #2 check(ale == 0, "R2 code 00 ignored", ale, 0);
    // io write with two wait states
    step(2'b01, 0, 1, 0, 0);
    step(2'b11, 0, 1, 0, 0);
    step(2'b11, 0, 1, 0, 0);
    step(2'b11, 0, 1, 0, 0);
    #2 check(ioWrN == 0, "R5 wait state holds command", ioWrN, 0);
    step(2'b11, 0, 0, 0, 0);
    step(2'b11, 0, 1, 0, 0);
    #2 check(ioWrN == 1, "R5 command released", ioWrN, 1);
    // write-write back to back, fast
    step(2'b01, 1, 1, 0, 0);
    step(2'b11, 1, 0, 0, 0);
    step(2'b01, 1, 0, 0, 0);
    #2 check(den && dtR, "R8 write data held", {den, dtR}, 3);
    step(2'b11, 1, 1, 0, 0);
    #2 check(ale && den && dtR, "R6 R8 back-to-back boundary", {ale, den, dtR}, 7);
    step(2'b11, 1, 0, 0, 0);
    step(2'b11, 1, 1, 0, 0);
    // write-write back to back, system-bus timing, with command delay
    doReset(1'b1);
    step(2'b01, 1, 1, 0, 0);
    step(2'b11, 1, 1, 1, 0);
    step(2'b11, 1, 1, 0, 0);
    #2 check(memWrN == 1, "R10 command delayed", memWrN, 1);
    step(2'b01, 1, 0, 0, 1);
    #2 check(memWrN == 1 && den == 1, "R11 address enable gates", {memWrN, den}, 3);
    step(2'b11, 1, 1, 0, 0);
    #2 check(ale && !den && !dtR, "R9 R6 data off in status", {ale, den, dtR}, 4);
    step(2'b11, 1, 0, 0, 0);
    step(2'b11, 1, 1, 0, 0);
    // random runs in each mode
    for (int m = 0; m < 2; m++) begin
      doReset(m[0]);
      for (int i = 0; i < 3000; i++) begin
        int r;
        logic [1:0] s;
        r = $urandom_range(0, 99);
        s = (r < 60) ? 2'b11 : (r < 75) ? 2'b10 : (r < 90) ? 2'b01 : 2'b00;
        step(s, logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
             logic'($urandom_range(0, 9) < 3), logic'($urandom_range(0, 9) < 2));
      end
      step(2'b11, 0, 0, 0, 0);
      step(2'b11, 0, 0, 0, 0);
      step(2'b11, 0, 0, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule